// File: doc/BRIEF.md
# Configuration Address Translator

The block sits between a host-side pair of configuration windows and a downstream configuration bus. The first window holds an index register. Software writes a 32-bit configuration address word into it. The second window is a data window. Each access to the data window is turned into one configuration bus transfer. The address of that transfer is built from the stored index word and the low bits of the access offset. The byte enables come from the access size and the offset.

The stored word is decoded in one of three formats:
- **Pass-through** (top bit set): the word is forwarded almost unchanged.
- **Type-1 style** (top bit clear, bit 0 set): the low three bits come from the access offset.
- **Slot-select** (all other words): the device is chosen by a one-hot bit. The lowest set bit at or above bit 11 is converted to a binary slot number. The function and register fields are copied alongside it, and the enable bit is set in the normalized address.

A slot-select word with no slot bit set selects nothing. Reads then return all ones and writes are lost. Every host access gets a one-cycle ready response. Data is little-endian and right-aligned on the host side.

Top module: `cfgx_xlate`

## Requirements
- R1: While reset is held and after it is released, the index register reads as zero and `rsp_ready` is low until an access is made.
- R2: Every host access with `req_valid` high gets `rsp_ready` high in the next cycle, with `rsp_rdata` valid in that same cycle. With no access, `rsp_ready` is low in the next cycle. A write response carries zero data.
- R3: A write to the index window (`req_win`=0) updates only the bytes selected by its byte enables. The index register changes on no other event. An index read returns the stored word through the read lane logic of R5.
- R4: The size codes are 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes.
  - The lane is `req_offset[1:0]` for 1 byte, `{req_offset[1],0}` for 2 bytes, and 0 for 4 bytes.
  - The byte enables are 1, 3 or F hex, shifted left by that lane.
  - Write data is taken from the low bytes of `req_wdata` and placed at the lane, with the other bytes zero.
- R5: Read data is shifted down by the lane so that the addressed byte lands on bit 0. Bits above the access size are zero.
- R6: If bit 31 of the index word is set, the forwarded address is the word OR'd with `req_offset[1:0]`.
- R7: If bit 31 is clear and bit 0 is set, the forwarded address is bits 31:3 of the word followed by `req_offset[2:0]`.
- R8: In all other cases with a bit set in 31:11, the forwarded address is formed as follows:
  - bit 31 is set;
  - bits 15:11 hold the slot, which is the position (11 to 30) of the lowest set bit among bits 31:11;
  - bits 10:8 are word bits 10:8;
  - bits 7:3 are word bits 7:3;
  - bits 2:0 are `req_offset[2:0]`;
  - all other bits are zero.
- R9: With bits 31:11 and bit 0 of the word all clear, a data access drives no `cfg_valid`. A read returns all ones, masked to the access size. A write changes nothing.
- R10: Each window is 4 KiB. Offset bits above bit 2 have no effect on data accesses, and offset bits above bit 1 have no effect on index accesses.
- R11: An index-window access never raises `cfg_valid`. A data access with a valid decode raises `cfg_valid`, together with the address, enables and data, in the same cycle as `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host access strobe, one cycle per access |
| req_win | input | 1 | 0 selects the index window, 1 selects the data window |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access size code (R4) |
| req_offset | input | OFS_W | Byte offset within the window |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_ready | output | 1 | Response strobe, one cycle after the access |
| rsp_rdata | output | 32 | Right-aligned read data |
| cfg_valid | output | 1 | Configuration bus transfer strobe |
| cfg_write | output | 1 | Transfer direction |
| cfg_addr | output | 32 | Normalized configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_rdata | input | 32 | Downstream read data, same cycle as `cfg_valid` |

## Verification
The forwarded transfer (`cfg_valid`, address, enables and data) is combinational and belongs to the same cycle as the request. The response and its data are due exactly one edge later. An index write first affects the access that follows it. The bench drives inputs just after the rising edge. A behavioural model takes its snapshot at the same rising edge as the design. Every output is compared at the falling edge. This places each comparison in the cycle where its result is due: forwarding in the request cycle, and the response in the cycle after it.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned CFGX_DW   = 32;
  localparam int unsigned CFGX_BE_W = CFGX_DW / 8;

  typedef enum logic [1:0] {
    CFGX_SZ_B1  = 2'd0,
    CFGX_SZ_B2  = 2'd1,
    CFGX_SZ_B4  = 2'd2,
    CFGX_SZ_B4X = 2'd3
  } cfgx_size_e;
endpackage

// File: rtl/cfgx_rst_sync.sv
module cfgx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/cfgx_lane_ctl.sv
module cfgx_lane_ctl
  import cfgx_pkg::*;
(
  input  logic [1:0]           lane_ofs,
  input  logic [1:0]           size,
  input  logic [CFGX_DW-1:0]   wdata_in,
  input  logic [CFGX_DW-1:0]   rdata_raw,
  output logic [CFGX_BE_W-1:0] be,
  output logic [CFGX_DW-1:0]   wdata_lane,
  output logic [CFGX_DW-1:0]   rdata_out
);
  logic [1:0]           lane;
  logic [CFGX_BE_W-1:0] be_base;
  logic [CFGX_DW-1:0]   keep_mask;
  logic [4:0]           sh;

  always_comb begin
    unique case (cfgx_size_e'(size))
      CFGX_SZ_B1: begin
        lane      = lane_ofs;
        be_base   = 4'b0001;
        keep_mask = 32'h0000_00FF;
      end
      CFGX_SZ_B2: begin
        lane      = {lane_ofs[1], 1'b0};
        be_base   = 4'b0011;
        keep_mask = 32'h0000_FFFF;
      end
      default: begin
        lane      = 2'd0;
        be_base   = 4'b1111;
        keep_mask = 32'hFFFF_FFFF;
      end
    endcase
    sh         = {lane, 3'b000};
    be         = be_base << lane;
    wdata_lane = (wdata_in & keep_mask) << sh;
    rdata_out  = (rdata_raw >> sh) & keep_mask;
  end
endmodule

// File: rtl/cfgx_slot_find.sv
module cfgx_slot_find #(
  parameter int unsigned W  = 32,
  parameter int unsigned LO = 11
) (
  input  logic [W-1:0]         word,
  output logic                 found,
  output logic [$clog2(W)-1:0] pos
);
  localparam int unsigned PW = $clog2(W);

  logic [W-1:LO] hit;

  genvar gi;
  generate
    for (gi = LO; gi < W; gi++) begin : g_hit
      if (gi == LO) begin : g_first
        assign hit[gi] = word[gi];
      end else begin : g_rest
        assign hit[gi] = word[gi] & ~(|word[gi-1:LO]);
      end
    end
  endgenerate

  always_comb begin
    pos = '0;
    for (int k = LO; k < W; k++) begin
      if (hit[k]) pos = pos | PW'(k);
    end
  end

  assign found = |word[W-1:LO];
endmodule

// File: rtl/cfgx_addr_decode.sv
module cfgx_addr_decode
  import cfgx_pkg::*;
#(
  parameter int unsigned SLOT_LO = 11
) (
  input  logic [CFGX_DW-1:0] idx_word,
  input  logic [2:0]         acc_ofs,
  output logic               fwd_ok,
  output logic [CFGX_DW-1:0] fwd_addr
);
  localparam int unsigned PW = $clog2(CFGX_DW);

  logic          slot_found;
  logic [PW-1:0] slot_pos;

  cfgx_slot_find #(.W(CFGX_DW), .LO(SLOT_LO)) u_slot (
    .word  (idx_word),
    .found (slot_found),
    .pos   (slot_pos)
  );

  always_comb begin
    fwd_ok   = 1'b1;
    fwd_addr = '0;
    if (idx_word[CFGX_DW-1]) begin
      fwd_addr = idx_word | {{(CFGX_DW-2){1'b0}}, acc_ofs[1:0]};
    end else if (idx_word[0]) begin
      fwd_addr = {idx_word[CFGX_DW-1:3], acc_ofs};
    end else if (slot_found) begin
      fwd_addr[CFGX_DW-1] = 1'b1;
      fwd_addr[15:11]     = slot_pos;
      fwd_addr[10:8]      = idx_word[10:8];
      fwd_addr[7:3]       = idx_word[7:3];
      fwd_addr[2:0]       = acc_ofs;
    end else begin
      fwd_ok = 1'b0;
    end
  end
endmodule

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg
  import cfgx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CFGX_BE_W-1:0] be,
  input  logic [CFGX_DW-1:0]   wdata_lane,
  output logic [CFGX_DW-1:0]   q
);
  logic [CFGX_DW-1:0] d;

  genvar gb;
  generate
    for (gb = 0; gb < CFGX_BE_W; gb++) begin : g_byte
      assign d[gb*8 +: 8] = be[gb] ? wdata_lane[gb*8 +: 8] : q[gb*8 +: 8];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= d;
  end
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
#(
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned SLOT_LO = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_win,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [31:0]      req_wdata,
  output logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic             cfg_valid,
  output logic             cfg_write,
  output logic [31:0]      cfg_addr,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic [31:0]      cfg_rdata
);
  logic                 rst_n_s;
  logic [CFGX_DW-1:0]   idx_q;
  logic                 dec_ok;
  logic [CFGX_DW-1:0]   dec_addr;
  logic [CFGX_BE_W-1:0] lane_be;
  logic [CFGX_DW-1:0]   lane_wdata;
  logic [CFGX_DW-1:0]   rd_raw;
  logic [CFGX_DW-1:0]   rd_lane;
  logic                 idx_we;
  logic                 rsp_en;
  logic                 rdy_d;
  logic [CFGX_DW-1:0]   rdata_d;
  logic                 unused_ofs_hi;

  assign unused_ofs_hi = ^req_offset[OFS_W-1:3];

  cfgx_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  cfgx_addr_decode #(.SLOT_LO(SLOT_LO)) u_dec (
    .idx_word (idx_q),
    .acc_ofs  (req_offset[2:0]),
    .fwd_ok   (dec_ok),
    .fwd_addr (dec_addr)
  );

  cfgx_lane_ctl u_lane (
    .lane_ofs   (req_offset[1:0]),
    .size       (req_size),
    .wdata_in   (req_wdata),
    .rdata_raw  (rd_raw),
    .be         (lane_be),
    .wdata_lane (lane_wdata),
    .rdata_out  (rd_lane)
  );

  assign idx_we = req_valid & ~req_win & req_write;

  cfgx_index_reg u_idx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (idx_we),
    .be         (lane_be),
    .wdata_lane (lane_wdata),
    .q          (idx_q)
  );

  always_comb begin
    rd_raw    = req_win ? (dec_ok ? cfg_rdata : '1) : idx_q;
    cfg_valid = req_valid & req_win & dec_ok;
    cfg_write = req_write;
    cfg_addr  = dec_addr;
    cfg_be    = lane_be;
    cfg_wdata = lane_wdata;
  end

  always_comb begin
    rsp_en  = req_valid | rsp_ready;
    rdy_d   = req_valid;
    rdata_d = (req_valid && !req_write) ? rd_lane : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
    end else if (rsp_en) begin
      rsp_ready <= rdy_d;
      rsp_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/cfgx_xlate_chk.sv
module cfgx_xlate_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        req_valid,
  input logic        req_win,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic        cfg_valid,
  input logic [3:0]  cfg_be,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic [31:0] idx_q
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> rsp_ready); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_valid |=> !rsp_ready); // R2
  AST_IDX_NO_FWD: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !req_win) |-> !cfg_valid); // R11
  AST_BE_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_valid && req_size == 2'd0) |-> $countones(cfg_be) == 1); // R4
  AST_BE_TWO_BYTE: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_valid && req_size == 2'd1) |-> (cfg_be == 4'b0011 || cfg_be == 4'b1100)); // R4
  AST_BE_FOUR_BYTE: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_valid && req_size[1]) |-> cfg_be == 4'b1111); // R4
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !(req_valid && !req_win && req_write) |=> $stable(idx_q)); // R3
  AST_ABSENT_READ_ONES: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_win && !req_write && !cfg_valid && req_size[1])
      |=> rsp_rdata == 32'hFFFF_FFFF); // R9
endmodule

bind cfgx_xlate cfgx_xlate_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_s),
  .req_valid (req_valid),
  .req_win   (req_win),
  .req_write (req_write),
  .req_size  (req_size),
  .cfg_valid (cfg_valid),
  .cfg_be    (cfg_be),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .idx_q     (idx_q)
);

// File: tb/tb_cfgx_xlate.sv
`timescale 1ns/1ps
module tb_cfgx_xlate;
  localparam int OFS_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_win = 1'b0;
  logic             req_write = 1'b0;
  logic [1:0]       req_size = 2'd0;
  logic [OFS_W-1:0] req_offset = '0;
  logic [31:0]      req_wdata = '0;
  logic             rsp_ready;
  logic [31:0]      rsp_rdata;
  logic             cfg_valid;
  logic             cfg_write;
  logic [31:0]      cfg_addr;
  logic [3:0]       cfg_be;
  logic [31:0]      cfg_wdata;
  logic [31:0]      cfg_rdata;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  cfgx_xlate #(.OFS_W(OFS_W), .SLOT_LO(11)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win),
    .req_write(req_write), .req_size(req_size), .req_offset(req_offset),
    .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // downstream device: data derived from the address it sees
  function automatic logic [31:0] m_resp(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16]};
  endfunction
  assign cfg_rdata = m_resp(cfg_addr);

  function automatic int m_lane(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'd0) return int'(o);
    if (sz == 2'd1) return o[1] ? 2 : 0;
    return 0;
  endfunction
  function automatic logic [31:0] m_mask(input logic [1:0] sz);
    if (sz == 2'd0) return 32'h0000_00FF;
    if (sz == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction
  function automatic logic [3:0] m_be(input logic [1:0] sz, input logic [1:0] o);
    logic [3:0] b;
    b = (sz == 2'd0) ? 4'h1 : (sz == 2'd1) ? 4'h3 : 4'hF;
    return b << m_lane(sz, o);
  endfunction
  function automatic logic [31:0] m_place(input logic [31:0] v, input logic [1:0] sz,
                                          input logic [1:0] o);
    return (v & m_mask(sz)) << (8 * m_lane(sz, o));
  endfunction
  function automatic logic [31:0] m_extract(input logic [31:0] w, input logic [1:0] sz,
                                            input logic [1:0] o);
    return (w >> (8 * m_lane(sz, o))) & m_mask(sz);
  endfunction
  task automatic m_decode(input logic [31:0] w, input logic [2:0] o,
                          output logic ok, output logic [31:0] a);
    int slot;
    ok = 1'b1;
    a  = '0;
    if (w[31]) a = w | {30'd0, o[1:0]};
    else if (w[0]) a = {w[31:3], o};
    else begin
      slot = -1;
      for (int i = 30; i >= 11; i--) if (w[i]) slot = i;
      if (slot < 0) ok = 1'b0;
      else a = 32'h8000_0000 + (slot << 11) + ({29'd0, w[10:8]} << 8)
               + ({27'd0, w[7:3]} << 3) + {29'd0, o};
    end
  endtask

  // reference state
  logic [31:0] m_idx;
  logic        exp_rdy;
  logic [31:0] exp_rdata;

  always @(posedge clk) begin : model
    logic        ok;
    logic [31:0] a;
    logic [31:0] raw;
    logic [31:0] pl;
    logic [3:0]  b;
    if (!rst_n) begin
      m_idx <= '0; exp_rdy <= 1'b0; exp_rdata <= '0;
    end else begin
      m_decode(m_idx, req_offset[2:0], ok, a);
      raw = req_win ? (ok ? m_resp(a) : 32'hFFFF_FFFF) : m_idx;
      exp_rdy   <= req_valid;
      exp_rdata <= (req_valid && !req_write) ? m_extract(raw, req_size, req_offset[1:0]) : '0;
      if (req_valid && !req_win && req_write) begin
        pl = m_place(req_wdata, req_size, req_offset[1:0]);
        b  = m_be(req_size, req_offset[1:0]);
        for (int k = 0; k < 4; k++) if (b[k]) m_idx[k*8 +: 8] <= pl[k*8 +: 8];
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin : compare
    logic        ok;
    logic [31:0] a;
    logic        fv;
    if (!done) begin
      m_decode(m_idx, req_offset[2:0], ok, a);
      fv = req_valid && req_win && ok;
      chk(cur_tag, "cfg_valid", {31'd0, cfg_valid}, {31'd0, fv});
      if (fv) begin
        chk(cur_tag, "cfg_addr", cfg_addr, a);
        chk("R4", "cfg_be", {28'd0, cfg_be}, {28'd0, m_be(req_size, req_offset[1:0])});
        chk(cur_tag, "cfg_write", {31'd0, cfg_write}, {31'd0, req_write});
        if (req_write)
          chk("R4", "cfg_wdata", cfg_wdata, m_place(req_wdata, req_size, req_offset[1:0]));
      end
      chk("R2", "rsp_ready", {31'd0, rsp_ready}, {31'd0, exp_rdy});
      if (exp_rdy) chk(cur_tag, "rsp_rdata", rsp_rdata, exp_rdata);
    end
  end

  task automatic acc(input logic win, input logic wr, input logic [1:0] sz,
                     input logic [OFS_W-1:0] off, input logic [31:0] wd);
    @(posedge clk); #1;
    req_valid = 1'b1; req_win = win; req_write = wr;
    req_size = sz; req_offset = off; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic set_idx(input logic [31:0] w);
    acc(1'b0, 1'b1, 2'd2, '0, w);
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    // R1: reset state, then release
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cur_tag = "R1";
    acc(1'b0, 1'b0, 2'd2, 12'h000, '0);

    // R9: decode of the zero index selects nothing
    cur_tag = "R9";
    acc(1'b1, 1'b0, 2'd2, 12'h000, '0);
    acc(1'b1, 1'b0, 2'd0, 12'h003, '0);
    acc(1'b1, 1'b1, 2'd2, 12'h000, 32'hDEAD_BEEF);

    // R3: index register with byte lanes
    cur_tag = "R3";
    set_idx(32'h8000_1234);
    acc(1'b0, 1'b0, 2'd2, 12'h000, '0);
    acc(1'b0, 1'b1, 2'd0, 12'h001, 32'hFFFF_FF56);
    acc(1'b0, 1'b1, 2'd1, 12'h002, 32'h0000_0A80);
    acc(1'b0, 1'b0, 2'd2, 12'h000, '0);
    cur_tag = "R5";
    for (int o = 0; o < 4; o++) acc(1'b0, 1'b0, 2'd0, 12'(o), '0);
    acc(1'b0, 1'b0, 2'd1, 12'h002, '0);
    acc(1'b0, 1'b0, 2'd1, 12'h001, '0);

    // R6: pass-through format
    cur_tag = "R6";
    set_idx(32'h8000_0A10);
    for (int o = 0; o < 8; o++) acc(1'b1, 1'b0, 2'd0, 12'(o), '0);
    acc(1'b1, 1'b0, 2'd1, 12'h006, '0);
    acc(1'b1, 1'b1, 2'd0, 12'h003, 32'h0000_00C3);
    acc(1'b1, 1'b1, 2'd1, 12'h002, 32'h1234_ABCD);
    acc(1'b1, 1'b1, 2'd3, 12'h001, 32'hCAFE_F00D);

    // R7: type-1 style format
    cur_tag = "R7";
    set_idx(32'h0012_345F);
    acc(1'b1, 1'b0, 2'd0, 12'h005, '0);
    acc(1'b1, 1'b0, 2'd2, 12'h007, '0);
    acc(1'b1, 1'b1, 2'd1, 12'h003, 32'h0000_7777);

    // R8: one-hot slot select, every slot position
    cur_tag = "R8";
    for (int s = 11; s <= 30; s++) begin
      set_idx((32'h1 << s) | ((s < 30) ? 32'h4000_0000 : 32'h0) | 32'h0000_03A6);
      acc(1'b1, 1'b0, 2'd0, 12'(s % 8), '0);
      acc(1'b1, 1'b1, 2'd1, 12'(s % 4), 32'h0000_BEEF);
    end

    // R9: absent slot with non-zero low fields
    cur_tag = "R9";
    set_idx(32'h0000_07FE);
    acc(1'b1, 1'b0, 2'd0, 12'h001, '0);
    acc(1'b1, 1'b0, 2'd1, 12'h002, '0);
    acc(1'b1, 1'b0, 2'd2, 12'h004, '0);
    acc(1'b1, 1'b1, 2'd2, 12'h000, 32'h1111_2222);
    acc(1'b0, 1'b0, 2'd2, 12'h000, '0);

    // R10: high offset bits alias
    cur_tag = "R10";
    set_idx(32'h0000_2A48);
    acc(1'b1, 1'b0, 2'd0, 12'hFFD, '0);
    acc(1'b1, 1'b0, 2'd0, 12'h005, '0);
    acc(1'b0, 1'b0, 2'd0, 12'h806, '0);
    acc(1'b0, 1'b1, 2'd0, 12'hFF1, 32'h0000_0099);
    acc(1'b0, 1'b0, 2'd2, 12'h7F8, '0);

    // R11: index accesses never forward, data access forwards in the same cycle
    cur_tag = "R11";
    set_idx(32'h8000_0800);
    acc(1'b0, 1'b0, 2'd2, 12'h000, '0);
    acc(1'b1, 1'b0, 2'd2, 12'h000, '0);

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    finish_run();
  end
endmodule